// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Master and Partial Reset

This block is a single-clock FIFO that offers two read styles. The style is fixed while the master reset is held low. In standard mode, the reader asks for each word with `rd_en`. The word is then registered onto `rd_data` at that clock edge. In fall-through mode, the oldest word moves onto `rd_data` without any request. In that mode `rd_en` takes the shown word and brings the next one forward. The read-side and write-side status pins change meaning with the mode. In standard mode they are active-low empty and full indications. In fall-through mode they are active-low "output word valid" and "space available" indications.

Three more active-low flags are derived from the current fill level: almost-empty, almost-full and half-full. The almost-empty and almost-full thresholds come from two offset registers. These registers are written through a small load port. The master reset returns them to their default values.

There are two asynchronous resets:
- The master reset clears all storage state, loads the default offsets and latches the mode pin.
- The partial reset clears the pointers, the held word and the output. It keeps the mode and both offsets as they are, so a running link can be flushed without being set up again.

Operation is defined only after a master reset.

Top module: `dual_mode_fifo`

## Requirements
- R1: While `mrst_n` is low, the mode is taken from `fwft_sel`: 0 selects standard mode and 1 selects fall-through mode. The mode does not change at any other time, including during a partial reset.
- R2: In standard mode, the reset state is as follows. `rd_side_flag` is 0 (empty), `wr_side_flag` is 1 (not full), `rd_data` is all zeroes, `almost_empty_n` is 0, `almost_full_n` is 1 and `half_full_n` is 1.
- R3: In fall-through mode, the reset state is as follows. `rd_side_flag` is 1 (no word shown), `wr_side_flag` is 0 (space available) and `rd_data` is all zeroes. The three level flags take the same values as in R2.
- R4: In standard mode, a `rd_en` at a clock edge with at least one stored word puts the oldest word on `rd_data` right after that edge. At every other edge, `rd_data` holds its value.
- R5: In fall-through mode, when no word is shown and memory holds a word, that word appears on `rd_data` at the next edge, with `rd_side_flag` going to 0. A word written into an empty FIFO therefore shows up after the second edge. `rd_en` while a word is shown takes it and brings the next one forward. If there is no next word, `rd_side_flag` returns to 1.
- R6: The memory holds DEPTH words. A write while it is full is ignored. In standard mode, `wr_side_flag` is 0 when DEPTH words are stored. In fall-through mode, `wr_side_flag` is 1 when the memory is full, which means DEPTH+1 words including the shown one.
- R7: A read request with nothing to give changes neither the read pointer nor `rd_data`. In standard mode, `rd_side_flag` is 0 exactly when no word is stored.
- R8: The fill level is the number of stored words. In fall-through mode it also counts the shown word. `almost_empty_n` is 0 when the level is less than or equal to the almost-empty offset.
- R9: `almost_full_n` is 0 when the level is greater than or equal to DEPTH minus the almost-full offset.
- R10: `half_full_n` is 0 when the level is greater than DEPTH/2.
- R11: A master reset sets both offsets to 7. When `ofs_load` is 1 at an edge, `ofs_value` is written to one offset register: `ofs_sel` = 0 selects the almost-empty offset and `ofs_sel` = 1 selects the almost-full offset. The offsets change at no other time.
- R12: A partial reset (`prst_n` low) empties the FIFO, zeroes `rd_data` and sets the flags to the reset values of the current mode. It keeps the mode and both offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Asynchronous master reset, active low |
| prst_n | input | 1 | Asynchronous partial reset, active low |
| fwft_sel | input | 1 | Mode pin, sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Output data register |
| rd_side_flag | output | 1 | Standard: not-empty; fall-through: word-shown, active low |
| wr_side_flag | output | 1 | Standard: not-full; fall-through: space-available, active low |
| almost_empty_n | output | 1 | Almost-empty, active low |
| almost_full_n | output | 1 | Almost-full, active low |
| half_full_n | output | 1 | Half-full, active low |
| ofs_load | input | 1 | Offset load strobe |
| ofs_sel | input | 1 | Offset select (0 = almost-empty, 1 = almost-full) |
| ofs_value | input | $clog2(DEPTH+2) | Offset value to load |

## Verification
Every flag and the standard-mode read data settle after the single rising edge that samples the command. They depend only on registered state.

The fall-through first word is due after two edges, because it passes through memory before reaching the output register. Both resets take effect at once, without waiting for an edge.

The bench steps a queue-based model on each rising edge and applies resets to it asynchronously, as the design does. All six outputs are compared at the following falling edge, so each result is read in the cycle it becomes due. Directed checks sample these same falling edges after a counted number of rising edges.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  // Words counted toward the level flags.
  function automatic int unsigned fill_level(int unsigned mem_words, logic shown, rd_mode_e m);
    return mem_words + (((m == MODE_FWFT) && shown) ? 32'd1 : 32'd0);
  endfunction

  // Active-low almost-empty: high only when the level is above the offset.
  function automatic logic ae_level_n(int unsigned lvl, int unsigned ofs);
    return lvl > ofs;
  endfunction

  // Active-low almost-full: low once lvl >= depth - ofs, written without subtraction.
  function automatic logic af_level_n(int unsigned lvl, int unsigned ofs, int unsigned depth);
    return (lvl + ofs) < depth;
  endfunction

  // Active-low half-full: low above half the depth.
  function automatic logic hf_level_n(int unsigned lvl, int unsigned depth);
    return lvl <= (depth / 32'd2);
  endfunction

endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 64,
  parameter int AW    = 6
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);

  logic [WIDTH-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  assign rdata = store[raddr];

endmodule

// File: rtl/dmf_ptrs.sv
module dmf_ptrs #(
  parameter int DEPTH = 64,
  parameter int AW    = 6,
  parameter int CW    = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [CW-1:0] mem_cnt,
  output logic          mem_full,
  output logic          mem_empty,
  output logic          wr_ok,
  output logic          pop_ok
);

  localparam bit POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [AW-1:0] wptr_nx, rptr_nx;

  if (POW2) begin : g_pow2
    assign wptr_nx = wptr + 1'b1;
    assign rptr_nx = rptr + 1'b1;
  end else begin : g_wrap
    assign wptr_nx = (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
    assign rptr_nx = (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
  end

  assign mem_full  = (mem_cnt == CW'(DEPTH));
  assign mem_empty = (mem_cnt == '0);
  assign wr_ok     = wr_en && !mem_full;
  assign pop_ok    = rd_pop && !mem_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      mem_cnt <= '0;
    end else begin
      if (wr_ok)  wptr <= wptr_nx;
      if (pop_ok) rptr <= rptr_nx;
      mem_cnt <= mem_cnt + CW'(wr_ok) - CW'(pop_ok);
    end
  end

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cnt <= CW'(DEPTH));

  // R6
  wr_full_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && mem_full) |=> $stable(wptr));

  // R7
  rd_empty_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_empty |=> $stable(rptr));

endmodule

// File: rtl/dmf_outstage.sv
module dmf_outstage
  import dmf_pkg::*;
#(
  parameter int WIDTH = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  rd_mode_e         mode,
  input  logic             rd_en,
  input  logic             mem_empty,
  input  logic             pop_ok,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             pop_req,
  output logic [WIDTH-1:0] out_data,
  output logic             out_valid
);

  // Standard: pop on request. Fall-through: pop whenever the slot is free or being taken.
  assign pop_req = (mode == MODE_FWFT) ? (!out_valid || rd_en) : rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (pop_ok) out_data <= mem_rdata;
      if (mode == MODE_FWFT) begin
        if (pop_ok)     out_valid <= 1'b1;
        else if (rd_en) out_valid <= 1'b0;
      end else begin
        out_valid <= 1'b0;
      end
    end
  end

  // R4
  std_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_STD && !pop_ok) |=> $stable(out_data));

  // R5
  fwft_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && !out_valid && !mem_empty) |=> out_valid);

  // R5
  fwft_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_FWFT && $fell(out_valid)) |-> $past(rd_en));

endmodule

// File: rtl/dmf_flags.sv
module dmf_flags
  import dmf_pkg::*;
#(
  parameter int DEPTH  = 64,
  parameter int CW     = 7,
  parameter int AE_DEF = 7,
  parameter int AF_DEF = 7
) (
  input  logic          clk,
  input  logic          mrst_n,
  input  rd_mode_e      mode,
  input  logic [CW-1:0] mem_cnt,
  input  logic          mem_full,
  input  logic          out_valid,
  input  logic          ofs_load,
  input  logic          ofs_sel,
  input  logic [CW-1:0] ofs_value,
  output logic          rd_side_flag,
  output logic          wr_side_flag,
  output logic          almost_empty_n,
  output logic          almost_full_n,
  output logic          half_full_n
);

  logic [CW-1:0] ae_ofs, af_ofs;
  int unsigned   level;

  // Offsets survive partial reset: only the master reset touches them.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) begin
      ae_ofs <= CW'(AE_DEF);
      af_ofs <= CW'(AF_DEF);
    end else if (ofs_load) begin
      if (ofs_sel) af_ofs <= ofs_value;
      else         ae_ofs <= ofs_value;
    end
  end

  assign level = fill_level(32'(mem_cnt), out_valid, mode);

  assign rd_side_flag   = (mode == MODE_FWFT) ? !out_valid : (mem_cnt != '0);
  assign wr_side_flag   = (mode == MODE_FWFT) ? mem_full   : !mem_full;
  assign almost_empty_n = ae_level_n(level, 32'(ae_ofs));
  assign almost_full_n  = af_level_n(level, 32'(af_ofs), DEPTH);
  assign half_full_n    = hf_level_n(level, DEPTH);

  // R11
  ofs_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    !ofs_load |=> ($stable(ae_ofs) && $stable(af_ofs)));

  // R8
  empty_ae_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    (mode == MODE_STD && !rd_side_flag) |-> !almost_empty_n);

endmodule

// File: rtl/dual_mode_fifo.sv
module dual_mode_fifo
  import dmf_pkg::*;
#(
  parameter  int WIDTH  = 18,
  parameter  int DEPTH  = 64,
  parameter  int AE_DEF = 7,
  parameter  int AF_DEF = 7,
  localparam int CW     = $clog2(DEPTH + 2)
) (
  input  logic             clk,
  input  logic             mrst_n,
  input  logic             prst_n,
  input  logic             fwft_sel,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_side_flag,
  output logic             wr_side_flag,
  output logic             almost_empty_n,
  output logic             almost_full_n,
  output logic             half_full_n,
  input  logic             ofs_load,
  input  logic             ofs_sel,
  input  logic [CW-1:0]    ofs_value
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  rd_mode_e         mode;
  logic             store_rst_n;
  logic [AW-1:0]    wptr, rptr;
  logic [CW-1:0]    mem_cnt;
  logic             mem_full, mem_empty, wr_ok, pop_ok, pop_req, out_valid;
  logic [WIDTH-1:0] mem_rdata;

  // Mode follows the pin for as long as master reset is held.
  always_ff @(posedge clk or negedge mrst_n) begin
    if (!mrst_n) mode <= fwft_sel ? MODE_FWFT : MODE_STD;
  end

  assign store_rst_n = mrst_n & prst_n;

  dmf_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
    .clk(clk), .rst_n(store_rst_n), .wr_en(wr_en), .rd_pop(pop_req),
    .wptr(wptr), .rptr(rptr), .mem_cnt(mem_cnt), .mem_full(mem_full),
    .mem_empty(mem_empty), .wr_ok(wr_ok), .pop_ok(pop_ok)
  );

  dmf_mem #(.WIDTH(WIDTH), .DEPTH(DEPTH), .AW(AW)) u_mem (
    .clk(clk), .we(wr_ok), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(mem_rdata)
  );

  dmf_outstage #(.WIDTH(WIDTH)) u_out (
    .clk(clk), .rst_n(store_rst_n), .mode(mode), .rd_en(rd_en),
    .mem_empty(mem_empty), .pop_ok(pop_ok), .mem_rdata(mem_rdata),
    .pop_req(pop_req), .out_data(rd_data), .out_valid(out_valid)
  );

  dmf_flags #(.DEPTH(DEPTH), .CW(CW), .AE_DEF(AE_DEF), .AF_DEF(AF_DEF)) u_flags (
    .clk(clk), .mrst_n(mrst_n), .mode(mode), .mem_cnt(mem_cnt),
    .mem_full(mem_full), .out_valid(out_valid), .ofs_load(ofs_load),
    .ofs_sel(ofs_sel), .ofs_value(ofs_value), .rd_side_flag(rd_side_flag),
    .wr_side_flag(wr_side_flag), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .half_full_n(half_full_n)
  );

  // R1
  mode_keep_chk: assert property (@(posedge clk) disable iff (!mrst_n)
    $stable(mode));

endmodule

// File: tb/dual_mode_fifo_tb.sv
module dual_mode_fifo_tb;
  localparam int W  = 18;
  localparam int DEPTH = 64;
  localparam int CW = $clog2(DEPTH + 2);

  logic clk = 1'b0;
  logic mrst_n = 1'b0, prst_n = 1'b1, fwft_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, ofs_load = 1'b0, ofs_sel = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic [CW-1:0] ofs_value = '0;
  logic [W-1:0] rd_data;
  logic rd_side_flag, wr_side_flag, almost_empty_n, almost_full_n, half_full_n;

  int checks = 0, errors = 0, cycles = 0;
  bit done = 1'b0;
  logic [W-1:0] seq = '0;

  // reference model state
  logic [W-1:0] q[$];
  bit m_fwft, m_ov;
  logic [W-1:0] m_out;
  int m_ae, m_af;

  always #2.5 clk = ~clk;

  dual_mode_fifo #(.WIDTH(W), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .rd_side_flag(rd_side_flag), .wr_side_flag(wr_side_flag),
    .almost_empty_n(almost_empty_n), .almost_full_n(almost_full_n),
    .half_full_n(half_full_n), .ofs_load(ofs_load), .ofs_sel(ofs_sel),
    .ofs_value(ofs_value)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Behavioural model: resets act at once, otherwise one step per rising edge.
  always @(posedge clk or negedge mrst_n or negedge prst_n) begin
    int cnt;
    bit take, wok;
    if (!mrst_n) begin
      m_fwft = fwft_sel; q.delete(); m_ov = 0; m_out = '0; m_ae = 7; m_af = 7;
    end else if (!prst_n) begin
      q.delete(); m_ov = 0; m_out = '0;
    end else begin
      cnt  = q.size();
      wok  = wr_en && (cnt < DEPTH);
      take = (m_fwft ? (!m_ov || rd_en) : rd_en) && (cnt > 0);
      if (take) begin
        m_out = q.pop_front();
        if (m_fwft) m_ov = 1;
      end else if (m_fwft && rd_en) begin
        m_ov = 0;
      end
      if (wok) q.push_back(wr_data);
      if (ofs_load) begin
        if (ofs_sel) m_af = int'(ofs_value);
        else         m_ae = int'(ofs_value);
      end
    end
  end

  // Compare every output half a period after each rising edge.
  always @(negedge clk) begin
    int lvl;
    lvl = q.size() + ((m_fwft && m_ov) ? 1 : 0);
    chk(m_fwft ? "R5" : "R4", rd_data, m_out);
    chk("R7", rd_side_flag, m_fwft ? !m_ov : (q.size() != 0));
    chk("R6", wr_side_flag, m_fwft ? (q.size() == DEPTH) : (q.size() != DEPTH));
    chk("R8", almost_empty_n, lvl > m_ae);
    chk("R9", almost_full_n, (lvl + m_af) < DEPTH);
    chk("R10", half_full_n, lvl <= DEPTH / 2);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_up();
    end
  end

  task automatic cyc(bit we, bit re);
    wr_en = we; rd_en = re;
    if (we) begin wr_data = seq; seq = seq + 1'b1; end
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic load_ofs(bit sel, int val);
    ofs_load = 1'b1; ofs_sel = sel; ofs_value = CW'(val);
    @(posedge clk); #1;
    ofs_load = 1'b0;
  endtask

  task automatic master_reset(bit pin);
    fwft_sel = pin; mrst_n = 1'b0;
    @(posedge clk); #1; @(posedge clk); #1;
    mrst_n = 1'b1;
  endtask

  task automatic partial_reset();
    prst_n = 1'b0;
    @(posedge clk); #1; @(posedge clk); #1;
    prst_n = 1'b1;
  endtask

  task automatic random_run(int n, int pw, int pr);
    for (int i = 0; i < n; i++) cyc(($urandom % 100) < pw, ($urandom % 100) < pr);
  endtask

  initial begin
    @(posedge clk); #1;
    master_reset(1'b0);
    @(negedge clk);
    // R1 standard mode selected; R2 reset levels
    chk("R1", {rd_side_flag, wr_side_flag}, 2'b01);
    chk("R2", rd_data, 0);
    chk("R2", {almost_empty_n, almost_full_n, half_full_n}, 3'b011);

    // R4 ordered reads in standard mode
    cyc(1, 0); cyc(1, 0); cyc(0, 1);
    @(negedge clk);
    chk("R4", rd_data, 0);
    cyc(0, 1);
    @(negedge clk);
    chk("R4", rd_data, 1);

    // R6 fill past full, R7 drain past empty
    for (int i = 0; i < DEPTH + 6; i++) cyc(1, 0);
    @(negedge clk);
    chk("R6", wr_side_flag, 0);
    for (int i = 0; i < DEPTH + 6; i++) cyc(0, 1);
    @(negedge clk);
    chk("R7", rd_side_flag, 0);

    random_run(300, 70, 30);
    random_run(300, 30, 70);

    // R12 partial reset keeps standard mode and the programmed offset
    load_ofs(0, 3);
    load_ofs(1, 12);
    random_run(40, 80, 20);
    partial_reset();
    @(negedge clk);
    chk("R12", rd_data, 0);
    chk("R12", {rd_side_flag, wr_side_flag}, 2'b01);
    for (int i = 0; i < 4; i++) cyc(1, 0);
    @(negedge clk);
    chk("R12", almost_empty_n, 1);
    random_run(200, 60, 40);

    // Fall-through mode
    master_reset(1'b1);
    @(negedge clk);
    chk("R1", {rd_side_flag, wr_side_flag}, 2'b10);
    chk("R3", rd_data, 0);
    chk("R3", {almost_empty_n, almost_full_n, half_full_n}, 3'b011);

    // R5 first word falls through after the second edge
    cyc(1, 0);
    @(negedge clk);
    chk("R5", rd_side_flag, 1);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R5", rd_side_flag, 0);
    chk("R5", rd_data, seq - 1'b1);

    // R11 default offset of 7 after master reset
    for (int i = 0; i < 6; i++) cyc(1, 0);
    cyc(0, 0); cyc(0, 0);
    @(negedge clk);
    chk("R11", almost_empty_n, 0);
    cyc(1, 0); cyc(0, 0);
    @(negedge clk);
    chk("R11", almost_empty_n, 1);

    // R6 capacity DEPTH+1 in fall-through mode
    for (int i = 0; i < DEPTH + 6; i++) cyc(1, 0);
    @(negedge clk);
    chk("R6", wr_side_flag, 1);
    chk("R9", almost_full_n, 0);
    chk("R10", half_full_n, 0);
    for (int i = 0; i < DEPTH + 8; i++) cyc(0, 1);
    @(negedge clk);
    chk("R7", rd_side_flag, 1);

    random_run(300, 70, 30);
    random_run(300, 35, 65);
    load_ofs(1, 20);
    random_run(300, 55, 45);

    // R12 partial reset keeps fall-through mode
    partial_reset();
    @(negedge clk);
    chk("R12", {rd_side_flag, wr_side_flag}, 2'b10);
    chk("R12", rd_data, 0);
    random_run(200, 60, 40);

    finish_up();
  end
endmodule